// File: doc/BRIEF.md
# Constant-Off-Time Current Chopper Sequencer

This block regulates the current of a three-phase bridge with a fixed off-time chopping scheme. A digital compare flag reports when the measured sense voltage has risen above the current reference. A commutation code names the leg that sources current and the leg that sinks it. From these inputs the block produces the high-side and low-side gate enables for every leg. Each chopping period runs through four phases: drive, a dead gap, a recirculation interval with the sinking leg's upper switch on as a synchronous rectifier, and a second dead gap before drive returns. In every phase the source leg's upper switch stays on, so during the off interval the current freewheels through the upper half of the bridge and decays slowly.

Dead time, comparator blanking, minimum on time and off time are counts of clock cycles set by parameters. Comparator blanking and the minimum on time are enforced together after every turn-on. The off timer starts when the low-side switch opens and covers the first dead gap and the rectifier interval, so the low-side switch stays off for the off count plus one dead time. A change of commutation code drops every switch for one dead time before the new pair of legs is driven. A phase code output reports which interval the bridge is in.

Top module: `chop_seq`

## Requirements
- R1: While reset is asserted, the phase code is 0 and every gate enable is low. If a valid commutation code is applied during reset, drive begins DEAD_CYC+1 cycles after the cycle in which reset is released.
- R2: In the drive phase (phase code 1) exactly two switches are on: the high side of the source leg and the low side of the sink leg. The third leg is fully off.
- R3: Counting drive-phase cycles from index 0, the compare flag has an effect only at an index c of at least H = max(BLANK_CYC, MIN_ON_CYC-1). A compare seen at index c ends drive after c+1 cycles, so drive lasts at least max(BLANK_CYC+1, MIN_ON_CYC) cycles.
- R4: When drive ends, the sink low side turns off first. For DEAD_CYC cycles (phase code 2) only the source high side is on.
- R5: The rectifier interval (phase code 3) lasts OFF_CYC-DEAD_CYC cycles, with both the source and sink high sides on. No low side is on in any phase other than drive.
- R6: After the rectifier interval, the sink high side turns off. For DEAD_CYC cycles (phase code 4) only the source high side is on, and then drive resumes.
- R7: No leg ever has its high side and low side on together. At most two legs have any switch on.
- R8: A change of either leg code forces phase code 0 with all gates off from the next cycle. This holds whatever the current phase. Drive on the new legs follows after DEAD_CYC cycles.
- R9: A commutation code is invalid when a leg code is NLEG or more, or when the source equals the sink. An invalid code keeps the block in phase 0 with every gate low for as long as it is applied.
- R10: The phase code takes the values 0 (all off), 1 (drive), 2 (first gap), 3 (rectifier) and 4 (second gap), and moves only in the order 1, 2, 3, 4, 1, except for the moves into and out of 0.
- R11: The compare flag has no effect outside the drive phase. Holding it high throughout leaves the gap and rectifier lengths unchanged, and drive lasts exactly H+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| over_ref_i | input | 1 | High when sense voltage exceeds the current reference |
| src_leg_i | input | LW (2) | Index of the leg that sources current |
| snk_leg_i | input | LW (2) | Index of the leg that sinks current |
| hs_en_o | output | NLEG (3) | High-side gate enable, one bit per leg |
| ls_en_o | output | NLEG (3) | Low-side gate enable, one bit per leg |
| phase_o | output | 3 | Bridge phase code, per R10 |

## Verification
The bench builds the block with DEAD_CYC=2, BLANK_CYC=3, MIN_ON_CYC=6 and OFF_CYC=7. These values make the compare threshold index 5 and a full chopping period about sixteen cycles long. With so short a period, every ordered source and sink pair can be swept against a compare arrival index from 0 to 8. Each sweep covers arrivals inside the blanked window, at the threshold and after it. Commutation changes are injected during drive and during the rectifier interval, and two invalid codes are applied. All expected lengths and gate patterns follow arithmetically from these four counts.

// File: rtl/chop_pkg.sv
package chop_pkg;

    // Bridge phase code reported on phase_o.
    typedef enum logic [2:0] {
        PH_OFF  = 3'd0,
        PH_ON   = 3'd1,
        PH_GAP1 = 3'd2,
        PH_SYNC = 3'd3,
        PH_GAP2 = 3'd4
    } chop_phase_e;

    // Index from which the compare flag may end the drive phase.
    function automatic int hold_index(input int blank_cyc, input int min_on_cyc);
        return (blank_cyc > min_on_cyc - 1) ? blank_cyc : min_on_cyc - 1;
    endfunction

endpackage

// File: rtl/chop_comm_check.sv
module chop_comm_check #(
    parameter int NLEG = 3,
    parameter int LW   = 2
) (
    input  logic [LW-1:0] src_leg_i,
    input  logic [LW-1:0] snk_leg_i,
    input  logic [LW-1:0] held_src_i,
    input  logic [LW-1:0] held_snk_i,
    output logic          valid_o,
    output logic          change_o
);

    always_comb begin
        valid_o  = (int'(src_leg_i) < NLEG) && (int'(snk_leg_i) < NLEG)
                   && (src_leg_i != snk_leg_i);
        change_o = (src_leg_i != held_src_i) || (snk_leg_i != held_snk_i);
    end

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int LW         = 2,
    parameter int DEAD_CYC   = 50,
    parameter int BLANK_CYC  = 50,
    parameter int MIN_ON_CYC = 125,
    parameter int OFF_CYC    = 650
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          over_ref_i,
    input  logic [LW-1:0] src_leg_i,
    input  logic [LW-1:0] snk_leg_i,
    input  logic          valid_i,
    input  logic          change_i,
    output chop_phase_e   phase_o,
    output logic [LW-1:0] held_src_o,
    output logic [LW-1:0] held_snk_o
);

    localparam int HOLD_IDX = hold_index(BLANK_CYC, MIN_ON_CYC);
    localparam int CW       = $clog2(OFF_CYC + BLANK_CYC + MIN_ON_CYC + 1);

    localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] OFF_LAST  = CW'(OFF_CYC - 1);
    localparam logic [CW-1:0] HOLD_C    = CW'(HOLD_IDX);

    typedef struct packed {
        chop_phase_e   ph;
        logic [CW-1:0] cnt;
        logic [LW-1:0] src;
        logic [LW-1:0] snk;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (change_i) begin
            // New legs: everything off, restart the dead gap.
            st_d.ph  = PH_OFF;
            st_d.cnt = '0;
            st_d.src = src_leg_i;
            st_d.snk = snk_leg_i;
        end else begin
            unique case (st_q.ph)
                PH_OFF: begin
                    if (st_q.cnt == DEAD_LAST) begin
                        if (valid_i) begin
                            st_d.ph  = PH_ON;
                            st_d.cnt = '0;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_ON: begin
                    if (over_ref_i && (st_q.cnt >= HOLD_C)) begin
                        st_d.ph  = PH_GAP1;
                        st_d.cnt = '0;
                    end else if (st_q.cnt < HOLD_C) begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_GAP1: begin
                    // Off timer keeps running into the rectifier interval.
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == DEAD_LAST) begin
                        st_d.ph = PH_SYNC;
                    end
                end
                PH_SYNC: begin
                    if (st_q.cnt == OFF_LAST) begin
                        st_d.ph  = PH_GAP2;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_GAP2: begin
                    if (st_q.cnt == DEAD_LAST) begin
                        st_d.ph  = PH_ON;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                    st_d.ph  = PH_OFF;
                    st_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ph  <= PH_OFF;
            st_q.cnt <= '0;
            st_q.src <= '1;
            st_q.snk <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o    = st_q.ph;
    assign held_src_o = st_q.src;
    assign held_snk_o = st_q.snk;

endmodule

// File: rtl/chop_gate_map.sv
module chop_gate_map
    import chop_pkg::*;
#(
    parameter int NLEG = 3,
    parameter int LW   = 2
) (
    input  chop_phase_e     phase_i,
    input  logic [LW-1:0]   src_i,
    input  logic [LW-1:0]   snk_i,
    output logic [NLEG-1:0] hs_en_o,
    output logic [NLEG-1:0] ls_en_o
);

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        logic is_src, is_snk;
        always_comb begin
            is_src     = (src_i == LW'(g));
            is_snk     = (snk_i == LW'(g));
            hs_en_o[g] = (is_src && (phase_i != PH_OFF))
                         || (is_snk && (phase_i == PH_SYNC));
            ls_en_o[g] = is_snk && (phase_i == PH_ON);
        end
    end

endmodule

// File: rtl/chop_seq.sv
module chop_seq
    import chop_pkg::*;
#(
    parameter int NLEG       = 3,
    parameter int DEAD_CYC   = 50,
    parameter int BLANK_CYC  = 50,
    parameter int MIN_ON_CYC = 125,
    parameter int OFF_CYC    = 650,
    localparam int LW        = $clog2(NLEG)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            over_ref_i,
    input  logic [LW-1:0]   src_leg_i,
    input  logic [LW-1:0]   snk_leg_i,
    output logic [NLEG-1:0] hs_en_o,
    output logic [NLEG-1:0] ls_en_o,
    output logic [2:0]      phase_o
);

    chop_phase_e   phase;
    logic [LW-1:0] held_src, held_snk;
    logic          comm_valid, comm_change;

    chop_comm_check #(.NLEG(NLEG), .LW(LW)) u_comm (
        .src_leg_i  (src_leg_i),
        .snk_leg_i  (snk_leg_i),
        .held_src_i (held_src),
        .held_snk_i (held_snk),
        .valid_o    (comm_valid),
        .change_o   (comm_change)
    );

    chop_ctrl #(
        .LW(LW), .DEAD_CYC(DEAD_CYC), .BLANK_CYC(BLANK_CYC),
        .MIN_ON_CYC(MIN_ON_CYC), .OFF_CYC(OFF_CYC)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .over_ref_i (over_ref_i),
        .src_leg_i  (src_leg_i),
        .snk_leg_i  (snk_leg_i),
        .valid_i    (comm_valid),
        .change_i   (comm_change),
        .phase_o    (phase),
        .held_src_o (held_src),
        .held_snk_o (held_snk)
    );

    chop_gate_map #(.NLEG(NLEG), .LW(LW)) u_map (
        .phase_i (phase),
        .src_i   (held_src),
        .snk_i   (held_snk),
        .hs_en_o (hs_en_o),
        .ls_en_o (ls_en_o)
    );

    assign phase_o = phase;

endmodule

// File: rtl/chop_seq_chk.sv
module chop_seq_chk
    import chop_pkg::*;
#(
    parameter int NLEG       = 3,
    parameter int LW         = 2,
    parameter int BLANK_CYC  = 50,
    parameter int MIN_ON_CYC = 125
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [LW-1:0]   src_leg_i,
    input logic [LW-1:0]   snk_leg_i,
    input logic [NLEG-1:0] hs_en_o,
    input logic [NLEG-1:0] ls_en_o,
    input logic [2:0]      phase_o
);

    localparam int HOLD_IDX = hold_index(BLANK_CYC, MIN_ON_CYC);
    localparam int RW       = $clog2(HOLD_IDX + 2);

    // Index of the current drive cycle, saturating past the hold index.
    logic [RW-1:0] on_run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            on_run_q <= '0;
        end else if (phase_o == PH_ON) begin
            if (on_run_q <= RW'(HOLD_IDX)) on_run_q <= on_run_q + 1'b1;
        end else begin
            on_run_q <= '0;
        end
    end

    assert_no_shoot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs_en_o & ls_en_o) == '0);

    assert_two_legs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(hs_en_o | ls_en_o) <= 2);

    assert_low_only_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o != PH_ON) |-> (ls_en_o == '0));

    assert_min_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o == PH_ON && on_run_q < RW'(HOLD_IDX)
         && src_leg_i == $past(src_leg_i) && snk_leg_i == $past(snk_leg_i))
        |=> (phase_o == PH_ON));

    assert_comm_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_leg_i != $past(src_leg_i) || snk_leg_i != $past(snk_leg_i))
        |=> (phase_o == PH_OFF && hs_en_o == '0 && ls_en_o == '0));

    for (genvar g = 0; g < NLEG; g++) begin : g_gap
        assert_gap_lo_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ls_en_o[g] |=> !hs_en_o[g]);
        assert_gap_hi_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            hs_en_o[g] |=> !ls_en_o[g]);
    end

endmodule

bind chop_seq chop_seq_chk #(
    .NLEG(NLEG), .LW(LW), .BLANK_CYC(BLANK_CYC), .MIN_ON_CYC(MIN_ON_CYC)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_leg_i (src_leg_i),
    .snk_leg_i (snk_leg_i),
    .hs_en_o   (hs_en_o),
    .ls_en_o   (ls_en_o),
    .phase_o   (phase_o)
);

// File: tb/chop_seq_tb.sv
module chop_seq_tb;

    localparam int DEAD     = 2;
    localparam int BLANK    = 3;
    localparam int MIN_ON   = 6;
    localparam int OFF      = 7;
    localparam int HOLD_IDX = (BLANK > MIN_ON - 1) ? BLANK : MIN_ON - 1;

    localparam logic [2:0] C_OFF = 3'd0, C_ON = 3'd1, C_GAP1 = 3'd2,
                           C_SYNC = 3'd3, C_GAP2 = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       over_ref = 1'b0;
    logic [1:0] src = 2'd0;
    logic [1:0] snk = 2'd1;
    logic [2:0] hs, ls, phase;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    chop_seq #(
        .NLEG(3), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK),
        .MIN_ON_CYC(MIN_ON), .OFF_CYC(OFF)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .over_ref_i(over_ref),
        .src_leg_i(src), .snk_leg_i(snk),
        .hs_en_o(hs), .ls_en_o(ls), .phase_o(phase)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_hs(input logic [2:0] ph, input int s, input int k);
        if (ph == C_OFF)  return 3'b000;
        if (ph == C_SYNC) return 3'(1 << s) | 3'(1 << k);
        return 3'(1 << s);
    endfunction

    function automatic logic [2:0] exp_ls(input logic [2:0] ph, input int k);
        return (ph == C_ON) ? 3'(1 << k) : 3'b000;
    endfunction

    // Counts consecutive cycles in phase ph, checking gates each cycle.
    task automatic span(input logic [2:0] ph, input int s, input int k,
                        input int ref_at, input int limit, input string req,
                        output int len);
        bit pat_ok = 1'b1;
        bit r7_ok = 1'b1;
        int got = 0;
        int want = 0;
        len = 0;
        while (phase == ph && len < limit) begin
            if (hs != exp_hs(ph, s, k) || ls != exp_ls(ph, k)) begin
                pat_ok = 1'b0;
                got  = {hs, ls};
                want = {exp_hs(ph, s, k), exp_ls(ph, k)};
            end
            if ((hs & ls) != 3'b000 || $countones(hs | ls) > 2) r7_ok = 1'b0;
            if (len == ref_at) over_ref = 1'b1;
            @(negedge clk);
            len++;
        end
        check(pat_ok, req, $sformatf("gate pattern phase %0d", ph), got, want);
        check(r7_ok, "R7", "leg exclusivity", int'(r7_ok), 1);
    endtask

    // One chopping period starting at a drive-phase negedge.
    task automatic full_cycle(input int s, input int k, input int j);
        int len;
        int exp_on;
        exp_on = ((j > HOLD_IDX) ? j : HOLD_IDX) + 1;
        span(C_ON, s, k, j, 60, "R2", len);
        check(len == exp_on, "R3", $sformatf("drive length j=%0d", j), len, exp_on);
        over_ref = 1'b0;
        span(C_GAP1, s, k, -1, 60, "R4", len);
        check(len == DEAD, "R4", "first gap length", len, DEAD);
        span(C_SYNC, s, k, -1, 60, "R5", len);
        check(len == OFF - DEAD, "R5", "rectifier length", len, OFF - DEAD);
        span(C_GAP2, s, k, -1, 60, "R6", len);
        check(len == DEAD, "R6", "second gap length", len, DEAD);
        check(phase == C_ON, "R10", "phase after second gap", phase, C_ON);
    endtask

    initial begin
        int len;
        bit first = 1'b1;
        repeat (3) @(negedge clk);
        check(phase == C_OFF, "R1", "phase in reset", phase, C_OFF);
        check(hs == 3'b0 && ls == 3'b0, "R1", "gates in reset", {hs, ls}, 0);
        rst_n = 1'b1;
        span(C_OFF, 0, 1, -1, 50, "R1", len);
        check(len == DEAD + 1, "R1", "off cycles after reset", len, DEAD + 1);

        // Sweep every ordered leg pair against compare arrival index.
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 3; k++) begin
                if (k != s) begin
                    if (!first) begin
                        src = 2'(s);
                        snk = 2'(k);
                        @(negedge clk);
                        span(C_OFF, s, k, -1, 50, "R8", len);
                        check(len == DEAD, "R8", "off after leg change", len, DEAD);
                    end
                    first = 1'b0;
                    for (int j = 0; j < 9; j++) full_cycle(s, k, j);
                end
            end
        end
        // Legs now src=2, snk=1, in drive.

        // R11: compare held high through a whole period.
        over_ref = 1'b1;
        span(C_ON, 2, 1, -1, 60, "R11", len);
        check(len == HOLD_IDX + 1, "R11", "drive with compare held", len, HOLD_IDX + 1);
        span(C_GAP1, 2, 1, -1, 60, "R11", len);
        check(len == DEAD, "R11", "gap with compare held", len, DEAD);
        span(C_SYNC, 2, 1, -1, 60, "R11", len);
        check(len == OFF - DEAD, "R11", "rectifier with compare held", len, OFF - DEAD);
        span(C_GAP2, 2, 1, -1, 60, "R11", len);
        check(len == DEAD, "R11", "second gap with compare held", len, DEAD);
        over_ref = 1'b0;

        // R8: change during drive, before the hold index.
        repeat (2) @(negedge clk);
        src = 2'd0;
        snk = 2'd2;
        @(negedge clk);
        check(phase == C_OFF && hs == 3'b0, "R8", "off after change in drive", {phase, hs}, 0);
        span(C_OFF, 0, 2, -1, 50, "R8", len);
        check(len == DEAD, "R8", "gap after change in drive", len, DEAD);
        full_cycle(0, 2, 6);

        // R8: change during the rectifier interval.
        span(C_ON, 0, 2, HOLD_IDX, 60, "R2", len);
        over_ref = 1'b0;
        span(C_GAP1, 0, 2, -1, 60, "R4", len);
        repeat (2) @(negedge clk);
        check(phase == C_SYNC, "R10", "still rectifying", phase, C_SYNC);
        src = 2'd1;
        snk = 2'd2;
        @(negedge clk);
        check(phase == C_OFF && hs == 3'b0 && ls == 3'b0, "R8",
              "off after change in rectifier", {phase, hs, ls}, 0);
        span(C_OFF, 1, 2, -1, 50, "R8", len);
        check(len == DEAD, "R8", "gap after change in rectifier", len, DEAD);
        full_cycle(1, 2, 7);

        // R9: invalid codes hold the bridge off.
        src = 2'd3;
        snk = 2'd0;
        @(negedge clk);
        span(C_OFF, 0, 0, -1, 20, "R9", len);
        check(len == 20, "R9", "off with leg code 3", len, 20);
        src = 2'd2;
        snk = 2'd2;
        over_ref = 1'b1;
        @(negedge clk);
        span(C_OFF, 0, 0, -1, 20, "R9", len);
        check(len == 20, "R9", "off with equal legs", len, 20);
        over_ref = 1'b0;
        src = 2'd1;
        snk = 2'd0;
        @(negedge clk);
        span(C_OFF, 1, 0, -1, 50, "R9", len);
        check(len == DEAD, "R9", "recovery gap", len, DEAD);
        full_cycle(1, 0, 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule